// File: doc/BRIEF.md
# Inductive Crosstalk Transition Legality Checker

This block judges whether a proposed move of one physical bus segment, from its current vector to its next vector, stays within inductive crosstalk and switching budgets. Each pin's move is reduced to a ternary value: +1 for rising, -1 for falling, 0 for holding. For every signal pin the block forms a signed coupling sum from the moves of its neighbours, weighted by distance. It then applies a pass rule that depends on the victim's own move. A quiet victim must not be disturbed too much. A switching victim must be helped, or at least not held back, by its neighbours. The segment as a whole is also limited in how many pins may rise, fall or switch together.

The segment is `SEG_W` pins wide. Its lowest position is the positive rail and its highest is the ground rail, and the segments on either side share this layout. Coupling reaches `REACH` pins in each direction, so a victim near an edge sees pins of the adjacent segments. Those pins enter through two narrow edge ports per side. The weights and every threshold are run-time inputs. One cycle after the inputs are sampled, the block presents a per-rule violation map and a single legal flag. A codec generator can use the flag to prune a transition graph, and the map tells the designer which rule removed a transition.

Top module: `xtalk_legal_chk`

## Requirements
- R1: While `rst_n` is low, `legal` reads 1 and `viol_map` reads all zeros, whatever the other inputs are.
- R2: A pin is rising when its previous bit is 0 and its next bit is 1, falling for 1 then 0, and static otherwise. The rail positions never switch, whatever their bits hold. Those positions are segment bits 0 and `SEG_W-1`, edge bit `REACH-2` of the left edge ports (the left segment's ground rail) and edge bit 0 of the right edge ports (the right segment's positive rail).
- R3: For signal pin i (1..SEG_W-2) the coupling sum is the total over q = 1..REACH of k_q times (move at i-q plus move at i+q). k_q is the signed byte `k_wts[(q-1)*W_K +: W_K]`. A position p below 0 is left edge bit p+REACH-1. A position p above SEG_W-1 is right edge bit p-SEG_W.
- R4: A static signal pin i sets map bit 3i-2 when its sum is at most -`glitch_lim` or at least +`glitch_lim` (signed). The bit is 0 whenever the pin is not static.
- R5: A rising signal pin i sets map bit 3i-1 when its sum is at most `rise_lim` (signed). The bit is 0 whenever the pin is not rising.
- R6: A falling signal pin i sets map bit 3i when its sum is at least `fall_lim` (signed). The bit is 0 whenever the pin is not falling.
- R7: Map bit 0 (positive rail bounce) is set when `bnc_unit` times the number of rising signal pins of the segment is at least `bnc_lim`. Both values are unsigned.
- R8: Map bit 3·SEG_W-5 (ground rail bounce) is set when `bnc_unit` times the number of falling signal pins of the segment is at least `bnc_lim`.
- R9: Map bit 3·SEG_W-4 (switching power) is set when the number of rising plus falling signal pins of the segment is at least `pwr_lim`.
- R10: `viol_map` and `legal` show the result for the inputs sampled at the previous rising clock edge, and `legal` is 1 exactly when no map bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_prev | input | SEG_W | Current vector of the segment, bit 0 = positive rail |
| seg_next | input | SEG_W | Proposed next vector of the segment |
| left_prev | input | REACH-1 | Current upper pins of the left neighbour segment |
| left_next | input | REACH-1 | Next upper pins of the left neighbour segment |
| right_prev | input | REACH-1 | Current lower pins of the right neighbour segment |
| right_next | input | REACH-1 | Next lower pins of the right neighbour segment |
| k_wts | input | REACH·W_K | Signed coupling weight per distance, distance 1 in the low byte |
| glitch_lim | input | TH_W | Signed bound for static victims |
| rise_lim | input | TH_W | Signed floor for rising victims |
| fall_lim | input | TH_W | Signed ceiling for falling victims |
| bnc_unit | input | W_K | Unsigned bounce cost of one switching pin on a rail |
| bnc_lim | input | TH_W | Unsigned rail bounce limit |
| pwr_lim | input | clog2(SEG_W) | Unsigned limit on switching pins |
| viol_map | output | 3·SEG_W-3 | Registered per-rule violation bits |
| legal | output | 1 | Registered flag, 1 when no rule is broken |

## Verification
The hardest cases to reach are sums that land exactly on a threshold, and sums that depend on pins of the neighbouring segments. Random vectors rarely hit an exact threshold, and only the outermost victims see the edge pins. Directed steps therefore pair a victim next to a segment boundary with one switching edge pin, then move the threshold across the resulting sum by one unit in both directions. Further steps toggle every rail bit, which must have no effect, and cancel a quiet victim's coupling with opposite moves on either side. Long random runs with weights, thresholds and sparse toggles changed every few cycles then cover the rest against a behavioural model.

// File: rtl/xtalk_pkg.sv
package xtalk_pkg;
  // Two-bit ternary move code, compared only by equality.
  typedef logic [1:0] trit_t;
  localparam trit_t TRIT_STILL = 2'b00;
  localparam trit_t TRIT_RISE  = 2'b01;
  localparam trit_t TRIT_FALL  = 2'b11;
endpackage

// File: rtl/xtalk_trit_cls.sv
module xtalk_trit_cls
  import xtalk_pkg::*;
#(
  parameter bit FIXED_RAIL = 1'b0
) (
  input  logic  prev_bit,
  input  logic  next_bit,
  output trit_t trit
);

  trit_t raw_move;

  always_comb begin
    unique case ({prev_bit, next_bit})
      2'b01:   raw_move = TRIT_RISE;
      2'b10:   raw_move = TRIT_FALL;
      default: raw_move = TRIT_STILL;
    endcase
    // supply positions hold a fixed level, so they never move
    trit = FIXED_RAIL ? TRIT_STILL : raw_move;
  end

endmodule

// File: rtl/xtalk_victim_chk.sv
module xtalk_victim_chk
  import xtalk_pkg::*;
#(
  parameter int REACH = 3,
  parameter int W_K   = 8,
  parameter int TH_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  trit_t                  victim,
  input  logic [2*REACH-1:0]     nbr_lo,
  input  logic [2*REACH-1:0]     nbr_hi,
  input  logic [REACH*W_K-1:0]   k_wts,
  input  logic [TH_W-1:0]        glitch_lim,
  input  logic [TH_W-1:0]        rise_lim,
  input  logic [TH_W-1:0]        fall_lim,
  output logic [2:0]             viol3
);

  localparam int SUM_W = W_K + $clog2(2 * REACH) + 1;
  localparam int CMP_W = ((SUM_W > TH_W) ? SUM_W : TH_W) + 1;

  logic signed [CMP_W-1:0] acc;
  logic signed [CMP_W-1:0] g_lim;
  logic signed [CMP_W-1:0] r_lim;
  logic signed [CMP_W-1:0] f_lim;

  function automatic logic signed [CMP_W-1:0] tern_term(
    input trit_t                   mv,
    input logic signed [CMP_W-1:0] w
  );
    if (mv == TRIT_RISE)      return w;
    else if (mv == TRIT_FALL) return -w;
    else                      return '0;
  endfunction

  assign g_lim = CMP_W'($signed(glitch_lim));
  assign r_lim = CMP_W'($signed(rise_lim));
  assign f_lim = CMP_W'($signed(fall_lim));

  // neighbour-weighted ternary coupling sum
  always_comb begin
    acc = '0;
    for (int q = 0; q < REACH; q++) begin
      logic signed [CMP_W-1:0] kq;
      kq  = CMP_W'($signed(k_wts[q*W_K +: W_K]));
      acc = acc + tern_term(trit_t'(nbr_lo[2*q +: 2]), kq)
                + tern_term(trit_t'(nbr_hi[2*q +: 2]), kq);
    end
  end

  always_comb begin
    viol3[0] = (victim == TRIT_STILL) && ((acc <= -g_lim) || (acc >= g_lim));
    viol3[1] = (victim == TRIT_RISE)  && (acc <= r_lim);
    viol3[2] = (victim == TRIT_FALL)  && (acc >= f_lim);
  end

  // R4 R5 R6: a victim has one move, so at most one of its rules can fire
  assert_one_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(viol3) <= 1);

  // R4: silent neighbours cannot disturb a quiet victim under a positive bound
  assert_quiet_nbr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nbr_lo == '0 && nbr_hi == '0 && $signed(glitch_lim) > 0) |-> !viol3[0]);

endmodule

// File: rtl/xtalk_rail_chk.sv
module xtalk_rail_chk
  import xtalk_pkg::*;
#(
  parameter int NSIG  = 5,
  parameter int W_K   = 8,
  parameter int TH_W  = 12,
  parameter int CNT_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NSIG-1:0]   sig_trits,
  input  logic [W_K-1:0]      bnc_unit,
  input  logic [TH_W-1:0]     bnc_lim,
  input  logic [CNT_W-1:0]    pwr_lim,
  output logic                vdd_v,
  output logic                vss_v,
  output logic                pwr_v
);

  localparam int BW = ((W_K + CNT_W) > TH_W) ? (W_K + CNT_W) : TH_W;

  logic [CNT_W-1:0] rise_cnt;
  logic [CNT_W-1:0] fall_cnt;
  logic [CNT_W-1:0] sw_cnt;
  logic [BW-1:0]    vdd_load;
  logic [BW-1:0]    vss_load;

  always_comb begin
    rise_cnt = '0;
    fall_cnt = '0;
    for (int i = 0; i < NSIG; i++) begin
      if (trit_t'(sig_trits[2*i +: 2]) == TRIT_RISE) rise_cnt = rise_cnt + CNT_W'(1);
      if (trit_t'(sig_trits[2*i +: 2]) == TRIT_FALL) fall_cnt = fall_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    sw_cnt   = rise_cnt + fall_cnt;
    vdd_load = BW'(bnc_unit) * BW'(rise_cnt);
    vss_load = BW'(bnc_unit) * BW'(fall_cnt);
    vdd_v    = vdd_load >= BW'(bnc_lim);
    vss_v    = vss_load >= BW'(bnc_lim);
    pwr_v    = sw_cnt >= pwr_lim;
  end

  // R7: with nothing rising the positive rail only trips on a zero limit
  assert_vdd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_cnt == '0 && bnc_lim != '0) |-> !vdd_v);

  // R8: same for the ground rail and falling pins
  assert_vss_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_cnt == '0 && bnc_lim != '0) |-> !vss_v);

endmodule

// File: rtl/xtalk_legal_chk.sv
module xtalk_legal_chk
  import xtalk_pkg::*;
#(
  parameter int SEG_W = 7,
  parameter int REACH = 3,
  parameter int W_K   = 8,
  parameter int TH_W  = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SEG_W-1:0]            seg_prev,
  input  logic [SEG_W-1:0]            seg_next,
  input  logic [REACH-2:0]            left_prev,
  input  logic [REACH-2:0]            left_next,
  input  logic [REACH-2:0]            right_prev,
  input  logic [REACH-2:0]            right_next,
  input  logic [REACH*W_K-1:0]        k_wts,
  input  logic [TH_W-1:0]             glitch_lim,
  input  logic [TH_W-1:0]             rise_lim,
  input  logic [TH_W-1:0]             fall_lim,
  input  logic [W_K-1:0]              bnc_unit,
  input  logic [TH_W-1:0]             bnc_lim,
  input  logic [$clog2(SEG_W)-1:0]    pwr_lim,
  output logic [3*SEG_W-4:0]          viol_map,
  output logic                        legal
);

  localparam int NSIG      = SEG_W - 2;
  localparam int EDGE_W    = REACH - 1;
  localparam int EXT_W     = SEG_W + 2 * EDGE_W;
  localparam int NUM_RULES = 3 * SEG_W - 3;
  localparam int CNT_W     = $clog2(SEG_W);
  localparam int VSS_BIT   = 3 * SEG_W - 5;
  localparam int PWR_BIT   = 3 * SEG_W - 4;

  logic [EXT_W-1:0]     ext_prev;
  logic [EXT_W-1:0]     ext_next;
  logic [2*EXT_W-1:0]   ext_trit;
  logic [NUM_RULES-1:0] viol_d;
  logic [NUM_RULES-1:0] viol_q;
  logic                 legal_d;
  logic                 legal_q;
  logic                 vdd_v;
  logic                 vss_v;
  logic                 pwr_v;

  // extended window: left edge pins, the segment, right edge pins
  assign ext_prev = {right_prev, seg_prev, left_prev};
  assign ext_next = {right_next, seg_next, left_next};

  for (genvar e = 0; e < EXT_W; e++) begin : g_cls
    localparam bit RAIL = (e == EDGE_W - 1) || (e == EDGE_W) ||
                          (e == EDGE_W + SEG_W - 1) || (e == EDGE_W + SEG_W);
    xtalk_trit_cls #(.FIXED_RAIL(RAIL)) u_cls (
      .prev_bit (ext_prev[e]),
      .next_bit (ext_next[e]),
      .trit     (ext_trit[2*e +: 2])
    );
  end

  for (genvar i = 1; i <= NSIG; i++) begin : g_vic
    localparam int C = EDGE_W + i;
    logic [2*REACH-1:0] lo_t;
    logic [2*REACH-1:0] hi_t;
    logic [2:0]         v3;
    for (genvar q = 0; q < REACH; q++) begin : g_tap
      assign lo_t[2*q +: 2] = ext_trit[2*(C-1-q) +: 2];
      assign hi_t[2*q +: 2] = ext_trit[2*(C+1+q) +: 2];
    end
    xtalk_victim_chk #(
      .REACH (REACH),
      .W_K   (W_K),
      .TH_W  (TH_W)
    ) u_vic (
      .clk        (clk),
      .rst_n      (rst_n),
      .victim     (trit_t'(ext_trit[2*C +: 2])),
      .nbr_lo     (lo_t),
      .nbr_hi     (hi_t),
      .k_wts      (k_wts),
      .glitch_lim (glitch_lim),
      .rise_lim   (rise_lim),
      .fall_lim   (fall_lim),
      .viol3      (v3)
    );
    assign viol_d[3*i-2 +: 3] = v3;
  end

  xtalk_rail_chk #(
    .NSIG  (NSIG),
    .W_K   (W_K),
    .TH_W  (TH_W),
    .CNT_W (CNT_W)
  ) u_rail (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_trits (ext_trit[2*(EDGE_W+1) +: 2*NSIG]),
    .bnc_unit  (bnc_unit),
    .bnc_lim   (bnc_lim),
    .pwr_lim   (pwr_lim),
    .vdd_v     (vdd_v),
    .vss_v     (vss_v),
    .pwr_v     (pwr_v)
  );

  assign viol_d[0]       = vdd_v;
  assign viol_d[VSS_BIT] = vss_v;
  assign viol_d[PWR_BIT] = pwr_v;

  // next state
  always_comb begin
    legal_d = ~|viol_d;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q  <= '0;
      legal_q <= 1'b1;
    end else begin
      viol_q  <= viol_d;
      legal_q <= legal_d;
    end
  end

  assign viol_map = viol_q;
  assign legal    = legal_q;

  // R10: the flag agrees with the registered map
  assert_legal_nor_R10: assert property (@(posedge clk) disable iff (!rst_n)
    legal == ~|viol_map);

  // R10: the map carries the evaluation of the previous edge
  assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (viol_map == $past(viol_d)));

endmodule

// File: tb/xtalk_legal_chk_bench.sv
module xtalk_legal_chk_bench;

  localparam int N   = 7;
  localparam int P   = 3;
  localparam int E   = P - 1;
  localparam int EXT = N + 2 * E;
  localparam int NR  = 3 * N - 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pv, nv;
  logic [E-1:0]  lp, ln, rp, rn;
  logic [P*8-1:0] kw;
  logic [11:0]   g_l, r_l, f_l, b_l;
  logic [7:0]    b_u;
  logic [2:0]    p_l;
  logic [NR-1:0] viol_map;
  logic          legal;

  int checks   = 0;
  int failures = 0;
  logic [NR-1:0] exp_viol;
  logic          exp_legal;
  bit            have_exp = 0;

  always #10 clk = ~clk;

  xtalk_legal_chk u_xtalk_legal_chk (
    .clk(clk), .rst_n(rst_n),
    .seg_prev(pv), .seg_next(nv),
    .left_prev(lp), .left_next(ln), .right_prev(rp), .right_next(rn),
    .k_wts(kw), .glitch_lim(g_l), .rise_lim(r_l), .fall_lim(f_l),
    .bnc_unit(b_u), .bnc_lim(b_l), .pwr_lim(p_l),
    .viol_map(viol_map), .legal(legal)
  );

  function automatic string tag(int b);
    if (b == 0) return "R7";
    if (b == NR - 2) return "R8";
    if (b == NR - 1) return "R9";
    case ((b - 1) % 3)
      0: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural model of the rules (R2 R3 R4 R5 R6 R7 R8 R9)
  task automatic predict();
    int mv[EXT];
    int rises = 0, falls = 0;
    for (int e = 0; e < EXT; e++) begin
      logic a, b;
      if (e < E)          begin a = lp[e];     b = ln[e];     end
      else if (e < E + N) begin a = pv[e-E];   b = nv[e-E];   end
      else                begin a = rp[e-E-N]; b = rn[e-E-N]; end
      mv[e] = (!a && b) ? 1 : (a && !b) ? -1 : 0;
      if (e == E - 1 || e == E || e == E + N - 1 || e == E + N) mv[e] = 0; // R2 rails
    end
    exp_viol = '0;
    for (int i = 1; i <= N - 2; i++) begin
      int c = E + i;
      int s = 0;
      for (int q = 1; q <= P; q++)
        s += int'($signed(kw[(q-1)*8 +: 8])) * (mv[c-q] + mv[c+q]); // R3
      if (mv[c] == 0) exp_viol[3*i-2] = (s <= -int'($signed(g_l))) || (s >= int'($signed(g_l)));
      if (mv[c] == 1) exp_viol[3*i-1] = (s <= int'($signed(r_l)));
      if (mv[c] == -1) exp_viol[3*i]  = (s >= int'($signed(f_l)));
      if (mv[c] == 1) rises++;
      if (mv[c] == -1) falls++;
    end
    exp_viol[0]    = (int'(b_u) * rises) >= int'(b_l);
    exp_viol[NR-2] = (int'(b_u) * falls) >= int'(b_l);
    exp_viol[NR-1] = (rises + falls) >= int'(p_l);
    exp_legal      = (exp_viol == '0);
    have_exp       = 1;
  endtask

  task automatic compare();
    if (!have_exp) return;
    for (int b = 0; b < NR; b++) begin
      checks++;
      if (viol_map[b] !== exp_viol[b]) begin
        failures++;
        $display("FAIL %s map bit %0d actual=%0b expected=%0b", tag(b), b, viol_map[b], exp_viol[b]);
      end
    end
    checks++;
    if (legal !== exp_legal) begin
      failures++;
      $display("FAIL R10 legal actual=%0b expected=%0b", legal, exp_legal);
    end
  endtask

  task automatic vec(input logic [N-1:0] a, input logic [N-1:0] b,
                     input logic [E-1:0] l0, input logic [E-1:0] l1,
                     input logic [E-1:0] r0, input logic [E-1:0] r1);
    @(negedge clk);
    compare();
    pv = a; nv = b; lp = l0; ln = l1; rp = r0; rn = r1;
    predict();
  endtask

  task automatic cfg(input logic [P*8-1:0] k, input int g, input int r, input int f,
                     input int u, input int bl, input int pl);
    @(negedge clk);
    compare();
    kw = k; g_l = 12'(g); r_l = 12'(r); f_l = 12'(f);
    b_u = 8'(u); b_l = 12'(bl); p_l = 3'(pl);
    predict();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    kw = 24'h010204; g_l = 12'd3; r_l = 12'd1; f_l = -12'sd1;
    b_u = 8'd2; b_l = 12'd7; p_l = 3'd4;
    pv = 7'b0000000; nv = 7'b0011110; // violating pattern held during reset
    lp = '0; ln = '0; rp = '0; rn = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (viol_map !== '0) begin
      failures++;
      $display("FAIL R1 reset map actual=%h expected=0", viol_map);
    end
    checks++;
    if (legal !== 1'b1) begin
      failures++;
      $display("FAIL R1 reset legal actual=%0b expected=1", legal);
    end
    @(negedge clk);
    rst_n = 1'b1;
    predict();

    // R2: all static, then rail-only toggles have no effect
    vec(7'b0000000, 7'b0000000, 2'b00, 2'b00, 2'b00, 2'b00);
    vec(7'b1000001, 7'b0000000, 2'b10, 2'b00, 2'b01, 2'b00);
    vec(7'b0000000, 7'b1000001, 2'b00, 2'b10, 2'b00, 2'b01);
    // R5: lone rising pin gets no help
    vec(7'b0000000, 7'b0001000, 2'b00, 2'b00, 2'b00, 2'b00);
    // R3 R5: three adjacent rising pins help each other
    vec(7'b0000000, 7'b0011100, 2'b00, 2'b00, 2'b00, 2'b00);
    // R7 R9: four rising pins exceed bounce and power budgets
    vec(7'b0000000, 7'b0011110, 2'b00, 2'b00, 2'b00, 2'b00);
    // R8: four falling pins
    vec(7'b0011110, 7'b0000000, 2'b00, 2'b00, 2'b00, 2'b00);
    // R4: opposite moves around a quiet pin cancel
    vec(7'b0010000, 7'b0000100, 2'b00, 2'b00, 2'b00, 2'b00);
    // R3 R5: left edge pin aids pin 1 by exactly k3 = 1; limit on and below it
    cfg(24'h010204, 10, 1, -1, 2, 7, 4);
    vec(7'b0000000, 7'b0000010, 2'b00, 2'b01, 2'b00, 2'b00);
    cfg(24'h010204, 10, 0, -1, 2, 7, 4);
    vec(7'b0000000, 7'b0000010, 2'b00, 2'b01, 2'b00, 2'b00);
    // R3 R6: right edge pin falls with pin 5; sum -1 against limits -1 and 0
    cfg(24'h010204, 10, 0, -1, 2, 7, 4);
    vec(7'b0100000, 7'b0000000, 2'b00, 2'b00, 2'b10, 2'b00);
    cfg(24'h010204, 10, 0, 0, 2, 7, 4);
    vec(7'b0100000, 7'b0000000, 2'b00, 2'b00, 2'b10, 2'b00);
    // R4: quiet pin with sum exactly at the bound
    cfg(24'h010204, 4, 0, 0, 2, 7, 4);
    vec(7'b0000000, 7'b0000010, 2'b00, 2'b00, 2'b00, 2'b00);
    cfg(24'h010204, 5, 0, 0, 2, 7, 4);
    vec(7'b0000000, 7'b0000010, 2'b00, 2'b00, 2'b00, 2'b00);

    // random sweep over weights, limits and sparse toggles
    for (int blk = 0; blk < 100; blk++) begin
      logic [P*8-1:0] k;
      for (int q = 0; q < P; q++) k[q*8 +: 8] = 8'(int'($urandom_range(0, 16)) - 8);
      cfg(k, int'($urandom_range(0, 12)), int'($urandom_range(0, 12)) - 6,
          int'($urandom_range(0, 12)) - 6, int'($urandom_range(0, 6)),
          int'($urandom_range(0, 20)), int'($urandom_range(0, 6)));
      for (int c = 0; c < 15; c++) begin
        logic [N-1:0] a;
        logic [E-1:0] l0, r0;
        a  = nv;
        l0 = ln;
        r0 = rn;
        vec(a, a ^ (N'($urandom) & N'($urandom)), l0, l0 ^ E'($urandom), r0, r0 ^ E'($urandom));
      end
    end
    @(negedge clk);
    compare();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule